// File: doc/BRIEF.md
# Streaming Random-Bit Health Tester

This block judges the statistical quality of a serial random bit stream, one bit per clock, over windows of 20,000 bits. A pulse on `start` arms it. It then takes every bit marked by `bit_valid` until the window is full. While the bits arrive, four tests run side by side:

- a ones count;
- a poker test on 4-bit segments;
- run-length histograms, kept separately for runs of ones and runs of zeros;
- a detector for overlong runs.

Two cycles after the last bit it raises `done` for one cycle, together with one pass flag per test and an overall verdict. It then goes idle until the next `start`. `clear` abandons a window at any time.

All arithmetic is integer. The poker limit is applied to sixteen times the sum of the squared segment frequencies, so no division is needed. Every counter saturates and never wraps.

Top module: `rng_health_tester`

## Requirements
- R1: After an accepted `start`, exactly 20,000 bits qualified by `bit_valid` form the window. `done` is high for exactly one cycle, two cycles after the cycle in which the last bit is presented.
- R2: `pass_ones` is 1 only when the window holds more than 9,654 and fewer than 10,346 ones (strict bounds).
- R3: The window is cut into 5,000 consecutive 4-bit segments, with the earliest bit of each segment as its MSB. With f(v) the occurrence count of value v, `pass_poker` is 1 only when 16·Σf(v)² is strictly above 25,005,150 and strictly below 25,287,000.
- R4: Maximal runs are counted by length class: 1, 2, 3, 4, 5, and 6 or longer. This is done separately for ones and for zeros. `pass_runs` is 1 only when, for both polarities, the counts lie inclusively within these bounds: 2267–2733, 1079–1421, 502–748, 223–402, 90–223 and 90–223.
- R5: `pass_long` is 0 when any run in the window is 34 bits or longer. A run of exactly 33 bits still passes.
- R6: The run still open at the last bit is closed and counted in the verdict.
- R7: `pass_all` is the AND of the four test flags. All five flags change only in the `done` cycle and hold their values until the next `done`.
- R8: Bits presented while idle are ignored. A `start` seen while a window is being collected or evaluated is ignored and does not restart the window.
- R9: `clear` returns the block to idle, discards the partial window and suppresses a `done` that would have come in the next cycle.
- R10: After reset, `done` and all five flags are 0 and the block is idle.
- R11: Run lengths and all counters saturate. A run longer than the run counter's range still counts once in the 6-or-more class and fails the long-run test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm a new window when idle |
| clear | input | 1 | Abort the current window |
| bit_valid | input | 1 | `bit_in` carries a sample this cycle |
| bit_in | input | 1 | Serial random bit |
| done | output | 1 | One-cycle verdict strobe |
| pass_ones | output | 1 | Ones-count test passed |
| pass_poker | output | 1 | Poker test passed |
| pass_runs | output | 1 | Run histogram test passed |
| pass_long | output | 1 | No overlong run |
| pass_all | output | 1 | All four tests passed |

## Verification
The last window bit is sampled at the end of its cycle. An evaluation stage follows in the next cycle, and `done` and the flags appear one cycle after that. The flags then stay fixed until the next verdict. The bench keeps a behavioural model that collects the accepted bits and computes every statistic from the stored window. The model steps once per input cycle and predicts the outputs for the following edge. The bench compares `done` and all flags on the falling edge of every cycle, so a verdict that arrives one cycle early or late shows as a mismatch. Fixed-value checks after chosen windows (all ones, alternating, runs of exactly 33 and 34 bits) confirm the boundaries.

// File: rtl/rht_pkg.sv
package rht_pkg;
  // number of run-length classes: 1,2,3,4,5 and 6-or-more
  localparam int NCLS = 6;
  // inclusive bounds per class, valid for a 20,000-bit window
  localparam int RUN_LO [NCLS] = '{2267, 1079, 502, 223, 90, 90};
  localparam int RUN_HI [NCLS] = '{2733, 1421, 748, 402, 223, 223};
endpackage

// File: rtl/rht_ones.sv
module rht_ones #(
  parameter int WIN_BITS = 20000,
  parameter int ONES_LO  = 9654,
  parameter int ONES_HI  = 10346
) (
  input  logic clk,
  input  logic clr,
  input  logic take,
  input  logic bit_in,
  output logic pass
);
  localparam int CW = $clog2(WIN_BITS + 1);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      ones_q <= '0;
    end else if (take && bit_in && (ones_q != '1)) begin
      ones_q <= ones_q + 1'b1;
    end
  end

  assign pass = (int'(ones_q) > ONES_LO) && (int'(ones_q) < ONES_HI);
endmodule

// File: rtl/rht_poker.sv
module rht_poker #(
  parameter int WIN_BITS = 20000,
  parameter int POKER_LO = 25005150,
  parameter int POKER_HI = 25287000
) (
  input  logic clk,
  input  logic clr,
  input  logic take,
  input  logic bit_in,
  output logic pass
);
  localparam int NSEG  = WIN_BITS / 4;
  localparam int FW    = $clog2(NSEG + 1);
  localparam int SQMAX = NSEG * NSEG;
  localparam int SW    = $clog2(SQMAX + 1);
  localparam logic [SW-1:0] SMAX = SW'(SQMAX);

  logic [2:0]    sh_q;
  logic [1:0]    pos_q;
  logic [3:0]    seg_val;
  logic          seg_end;
  logic [FW-1:0] freq_all [16];
  logic [FW-1:0] fcur;
  logic [SW-1:0] sum_q;
  logic [SW:0]   sum_nxt;
  logic [SW+3:0] sum16;

  assign seg_val = {sh_q, bit_in};
  assign seg_end = take && (pos_q == 2'd3);

  always_ff @(posedge clk) begin
    if (clr) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (take) begin
      sh_q  <= {sh_q[1:0], bit_in};
      pos_q <= pos_q + 1'b1;
    end
  end

  for (genvar g = 0; g < 16; g++) begin : g_freq
    logic [FW-1:0] f_q;
    always_ff @(posedge clk) begin
      if (clr) begin
        f_q <= '0;
      end else if (seg_end && (seg_val == 4'(g)) && (f_q != '1)) begin
        f_q <= f_q + 1'b1;
      end
    end
    assign freq_all[g] = f_q;
  end

  // (f+1)^2 - f^2 = 2f+1: keep the square sum current one segment at a time
  assign fcur    = freq_all[seg_val];
  assign sum_nxt = {1'b0, sum_q} + (SW+1)'({fcur, 1'b1});

  always_ff @(posedge clk) begin
    if (clr) begin
      sum_q <= '0;
    end else if (seg_end && (fcur != '1)) begin
      sum_q <= (sum_nxt > {1'b0, SMAX}) ? SMAX : sum_nxt[SW-1:0];
    end
  end

  assign sum16 = {sum_q, 4'b0000};
  assign pass  = (64'(sum16) > 64'(POKER_LO)) && (64'(sum16) < 64'(POKER_HI));
endmodule

// File: rtl/rht_runs.sv
module rht_runs
  import rht_pkg::*;
#(
  parameter int WIN_BITS = 20000,
  parameter int LONG_MAX = 33
) (
  input  logic clk,
  input  logic clr,
  input  logic take,
  input  logic last,
  input  logic bit_in,
  output logic pass_runs,
  output logic pass_long
);
  localparam int RMAX = (LONG_MAX + 1 > NCLS) ? LONG_MAX + 1 : NCLS;
  localparam int RLW  = $clog2(RMAX + 1);
  localparam int HW   = $clog2(WIN_BITS + 1);
  localparam int CLW  = $clog2(NCLS);

  logic                     prev_q, have_q, long_q;
  logic [RLW-1:0]           len_q, len_nxt;
  logic                     same, close_old, close_new;
  logic [1:0]               inc_en;
  logic [1:0][CLW-1:0]      inc_cls;
  logic [2*NCLS-1:0]        band_ok;

  function automatic logic [CLW-1:0] len_cls(input logic [RLW-1:0] l);
    if (int'(l) >= NCLS) return CLW'(NCLS - 1);
    else                 return CLW'(int'(l) - 1);
  endfunction

  assign same      = have_q && (bit_in == prev_q);
  assign len_nxt   = !same ? RLW'(1) : ((len_q == RLW'(RMAX)) ? len_q : len_q + 1'b1);
  assign close_old = take && have_q && !same;
  assign close_new = take && last;

  always_comb begin
    inc_en  = '0;
    inc_cls = '0;
    if (close_old) begin
      inc_en[prev_q]  = 1'b1;
      inc_cls[prev_q] = len_cls(len_q);
    end
    if (close_new) begin
      inc_en[bit_in]  = 1'b1;
      inc_cls[bit_in] = len_cls(len_nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
      long_q <= 1'b0;
      len_q  <= '0;
    end else if (take) begin
      prev_q <= bit_in;
      have_q <= 1'b1;
      len_q  <= len_nxt;
      if (int'(len_nxt) > LONG_MAX) long_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pol
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      logic [HW-1:0] h_q;
      always_ff @(posedge clk) begin
        if (clr) begin
          h_q <= '0;
        end else if (inc_en[p] && (inc_cls[p] == CLW'(c)) && (h_q != '1)) begin
          h_q <= h_q + 1'b1;
        end
      end
      assign band_ok[p*NCLS + c] = (int'(h_q) >= RUN_LO[c]) && (int'(h_q) <= RUN_HI[c]);
    end
  end

  assign pass_runs = &band_ok;
  assign pass_long = !long_q;
endmodule

// File: rtl/rng_health_tester.sv
module rng_health_tester #(
  parameter int WIN_BITS = 20000,
  parameter int ONES_LO  = 9654,
  parameter int ONES_HI  = 10346,
  parameter int POKER_LO = 25005150,
  parameter int POKER_HI = 25287000,
  parameter int LONG_MAX = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  input  logic bit_valid,
  input  logic bit_in,
  output logic done,
  output logic pass_ones,
  output logic pass_poker,
  output logic pass_runs,
  output logic pass_long,
  output logic pass_all
);
  localparam int CW = $clog2(WIN_BITS + 1);

  logic          busy, eval_q;
  logic [CW-1:0] bit_cnt;
  logic          go, take, last, wipe;
  logic          r_ones, r_poker, r_runs, r_long;

  assign go   = !busy && !eval_q && start && !clear;
  assign take = busy && bit_valid && !clear;
  assign last = take && (bit_cnt == CW'(WIN_BITS - 1));
  assign wipe = rst || clear || go;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      eval_q  <= 1'b0;
      bit_cnt <= '0;
    end else begin
      eval_q <= last;
      if (clear) begin
        busy <= 1'b0;
      end else if (go) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
      end else if (take) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      pass_ones  <= 1'b0;
      pass_poker <= 1'b0;
      pass_runs  <= 1'b0;
      pass_long  <= 1'b0;
      pass_all   <= 1'b0;
    end else begin
      done <= eval_q && !clear;
      if (eval_q && !clear) begin
        pass_ones  <= r_ones;
        pass_poker <= r_poker;
        pass_runs  <= r_runs;
        pass_long  <= r_long;
        pass_all   <= r_ones && r_poker && r_runs && r_long;
      end
    end
  end

  rht_ones #(.WIN_BITS(WIN_BITS), .ONES_LO(ONES_LO), .ONES_HI(ONES_HI)) u_ones (
    .clk(clk), .clr(wipe), .take(take), .bit_in(bit_in), .pass(r_ones));

  rht_poker #(.WIN_BITS(WIN_BITS), .POKER_LO(POKER_LO), .POKER_HI(POKER_HI)) u_poker (
    .clk(clk), .clr(wipe), .take(take), .bit_in(bit_in), .pass(r_poker));

  rht_runs #(.WIN_BITS(WIN_BITS), .LONG_MAX(LONG_MAX)) u_runs (
    .clk(clk), .clr(wipe), .take(take), .last(last), .bit_in(bit_in),
    .pass_runs(r_runs), .pass_long(r_long));
endmodule

// File: rtl/rht_checker.sv
module rht_checker #(
  parameter int WIN_BITS = 20000
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           clear,
  input logic                           done,
  input logic                           busy,
  input logic [$clog2(WIN_BITS+1)-1:0]  bit_cnt,
  input logic [4:0]                     flags
);
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(bit_cnt) < WIN_BITS));

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(flags));

  a_r9_clear_abort: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!busy && !done));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !clear) |=> (!busy || (bit_cnt >= $past(bit_cnt))));
endmodule

bind rng_health_tester rht_checker #(.WIN_BITS(WIN_BITS)) u_rht_chk (
  .clk(clk), .rst(rst), .clear(clear), .done(done), .busy(busy), .bit_cnt(bit_cnt),
  .flags({pass_ones, pass_poker, pass_runs, pass_long, pass_all}));

// File: tb/rng_health_tester_bench.sv
module rng_health_tester_bench;
  localparam int WIN = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, clear = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic done, pass_ones, pass_poker, pass_runs, pass_long, pass_all;

  always #5 clk = ~clk;

  rng_health_tester u_rng_health_tester (
    .clk(clk), .rst(rst), .start(start), .clear(clear), .bit_valid(bit_valid),
    .bit_in(bit_in), .done(done), .pass_ones(pass_ones), .pass_poker(pass_poker),
    .pass_runs(pass_runs), .pass_long(pass_long), .pass_all(pass_all));

  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  string scen = "R10";

  // reference model state
  bit       mbits [WIN];
  int       mcount = 0;
  bit       m_busy = 0, m_pend = 0;
  bit [4:0] m_res = '0;
  bit       e_done = 0;
  bit [4:0] e_flags = '0;
  bit [31:0] lfsr = 32'h1234_ABCD;

  task automatic chk(input string req, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0b expected=%0b at %0t", req, scen, act, exp, $time);
    end
  endtask

  function automatic bit [4:0] evaluate();
    int ones = 0;
    longint f [16];
    longint s16 = 0;
    int hist [2][6];
    int maxrun = 0;
    int len = 0;
    bit o, p, r, l;
    for (int v = 0; v < 16; v++) f[v] = 0;
    for (int a = 0; a < 2; a++) for (int c = 0; c < 6; c++) hist[a][c] = 0;
    for (int i = 0; i < WIN; i++) ones += mbits[i];
    o = (ones > 9654) && (ones < 10346);
    for (int sg = 0; sg < WIN/4; sg++)
      f[mbits[4*sg]*8 + mbits[4*sg+1]*4 + mbits[4*sg+2]*2 + mbits[4*sg+3]]++;
    for (int v = 0; v < 16; v++) s16 += 16 * f[v] * f[v];
    p = (s16 > 25005150) && (s16 < 25287000);
    for (int i = 0; i < WIN; i++) begin
      len++;
      if (i == WIN-1 || mbits[i+1] != mbits[i]) begin
        hist[mbits[i]][(len >= 6) ? 5 : len-1]++;
        if (len > maxrun) maxrun = len;
        len = 0;
      end
    end
    r = 1;
    for (int a = 0; a < 2; a++) begin
      if (hist[a][0] < 2267 || hist[a][0] > 2733) r = 0;
      if (hist[a][1] < 1079 || hist[a][1] > 1421) r = 0;
      if (hist[a][2] < 502  || hist[a][2] > 748)  r = 0;
      if (hist[a][3] < 223  || hist[a][3] > 402)  r = 0;
      if (hist[a][4] < 90   || hist[a][4] > 223)  r = 0;
      if (hist[a][5] < 90   || hist[a][5] > 223)  r = 0;
    end
    l = (maxrun <= 33);
    return {o, p, r, l, o & p & r & l};
  endfunction

  task automatic step(input bit s, input bit c, input bit v, input bit b);
    bit np;
    @(negedge clk);
    chk("R1", done, e_done);
    chk("R2", pass_ones, e_flags[4]);
    chk("R3", pass_poker, e_flags[3]);
    chk("R4", pass_runs, e_flags[2]);
    chk("R5", pass_long, e_flags[1]);
    chk("R7", pass_all, e_flags[0]);
    start = s; clear = c; bit_valid = v; bit_in = b;
    e_done = m_pend && !c;
    if (e_done) e_flags = m_res;
    np = 0;
    if (c) m_busy = 0;
    else if (!m_busy && !m_pend && s) begin m_busy = 1; mcount = 0; end
    else if (m_busy && v) begin
      mbits[mcount] = b;
      mcount++;
      if (mcount == WIN) begin m_busy = 0; np = 1; m_res = evaluate(); end
    end
    m_pend = np;
  endtask

  function automatic bit lfsr_bit();
    bit o = lfsr[0];
    lfsr = lfsr[0] ? ((lfsr >> 1) ^ 32'h8020_0003) : (lfsr >> 1);
    return o;
  endfunction

  // kind: 0 random with gaps, 1 all ones, 2 alternating, 3 embedded 33-run, 4 ends with 34 ones
  task automatic run_window(input int kind);
    bit b;
    step(1, 0, 0, 0);
    for (int i = 0; i < WIN; i++) begin
      case (kind)
        1: b = 1;
        2: b = i[0];
        3: b = (i == 9000 || i == 9034) ? 1'b0 : ((i > 9000 && i < 9034) ? 1'b1 : lfsr_bit());
        4: b = (i >= WIN-34) ? 1'b1 : lfsr_bit();
        default: b = lfsr_bit();
      endcase
      if (kind == 0 && i % 16 == 7) step(0, 0, 0, 1);     // invalid cycle, bit ignored
      step((kind == 0 && i == 5000) ? 1'b1 : 1'b0, 0, 1, b); // R8: start mid-window ignored
    end
    repeat (3) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", done, 0); chk("R10", pass_ones, 0); chk("R10", pass_poker, 0);
    chk("R10", pass_runs, 0); chk("R10", pass_long, 0); chk("R10", pass_all, 0);
    rst = 1'b0;
    scen = "R8";
    for (int i = 0; i < 40; i++) step(0, 0, 1, i[1]);   // idle bits ignored
    run_window(0);
    scen = "R11";
    run_window(1);
    chk("R11", pass_ones, 0); chk("R11", pass_poker, 0); chk("R11", pass_runs, 0);
    chk("R11", pass_long, 0); chk("R11", pass_all, 0);
    scen = "R4";
    run_window(2);
    chk("R2", pass_ones, 1); chk("R3", pass_poker, 0); chk("R4", pass_runs, 0);
    chk("R5", pass_long, 1);
    scen = "R9";
    step(1, 0, 0, 0);
    for (int i = 0; i < 500; i++) step(0, 0, 1, 1'b1);
    step(0, 1, 1, 1'b1);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 1'b1);
    chk("R9", pass_long, 1);   // flags still hold the previous verdict
    scen = "R5";
    run_window(3);
    chk("R5", pass_long, 1);
    scen = "R6";
    run_window(4);
    chk("R6", pass_long, 0);
    chk("R6", pass_all, 0);
    step(0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(190000 * 10);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog [%s] actual=running expected=finished", scen);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule